// File: doc/BRIEF.md
# Byte-Stream DMA Engine with Residual Word Register

This engine moves an arbitrary number of bytes between a byte-wide peripheral and a word-wide memory. Toward memory it only ever issues full, word-aligned accesses. Bytes arriving from the peripheral are packed into a word buffer, with the first byte in the most significant lane. The buffer is written to memory once its last lane fills.

When a device-to-memory transfer ends partway through a word, those bytes are not written. They stay in a residual register that software reads out. The low address bits then tell software how many lanes are valid. In the memory-to-device direction, the engine fetches a word and hands it out lane by lane, fetching the next word after the last lane.

Software works through four registers. It programs address and count while the engine is disabled, then sets the enable bit. It then watches the completion and bus-error flags. The address register is the exact progress measure, because it also counts the bytes held in the residual register.

Top module: `bytedma_rest`

## Requirements
- R1: After reset the status read (select 0) is zero, `dev_ack` stays low while `dev_req` is high, and `mem_req` is low.
- R2: Register select 0 is control on write and status on read, 1 is address, 2 is count and 3 is the residual word. Control bit 0 is direction (1 = memory to device) and bit 1 is enable. Status bit 7 is bus error, bit 6 is done, bit 1 echoes enable and bit 0 echoes direction; all other status bits are zero. Address and count writes are ignored while enable is set.
- R3: Device to memory: each handshake stores the byte in lane `addr[1:0]`, where lane 0 is bits 31:24. Each handshake increments the address and decrements the count by one. The handshake that fills lane 3 issues a write (`mem_we`=1) of the whole word to the word-aligned address.
- R4: No handshake (`dev_ack`) is granted while a memory access is outstanding.
- R5: After a device-to-memory transfer ends, the residual register holds the unwritten bytes from lane 0 upward, with the unused lanes zero. `addr[1:0]` equals the number of bytes held there.
- R6: Memory to device: the engine reads the word-aligned word and presents lane `addr[1:0]` on `dev_wdata`, most significant lane first. It starts a new read after lane 3 is consumed.
- R7: Status bit 6 is set once the count is zero and no memory access is outstanding. If the last byte completes a word, the flag waits for that write to be acknowledged.
- R8: `mem_err` ends the transfer. It sets status bit 7, leaves bit 6 clear, loads the address with the faulting word address, and no further handshakes follow.
- R9: A control write with bit 1 clear stops the engine, abandons any outstanding memory access and clears status bits 7 and 6.
- R10: Enabling with a count of zero sets done without any memory access or handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_sel` |
| dev_req | input | 1 | Peripheral has a byte / wants a byte |
| dev_ack | output | 1 | Byte handshake; transfer on the edge where both are high |
| dev_rdata | input | 8 | Byte from peripheral |
| dev_wdata | output | 8 | Byte to peripheral |
| mem_req | output | 1 | Memory access request, held until a response |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Word-aligned memory address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with `mem_ack` |
| mem_ack | input | 1 | Access completed |
| mem_err | input | 1 | Access failed with a bus error |

## Verification
The handshake that fills the last lane of a word can also drive the count to zero. In that cycle the word write and the completion condition meet. The bench provokes this with an eight-byte inbound transfer against a slow memory. Right after the final handshake it expects `mem_req` high and the done bit still clear. The done bit must then rise only after the acknowledge, with both words in memory. A second overlap, a bus error on a word flush, is judged by the error flag, the rewound address and the absence of any later handshake.

// File: rtl/bytedma_pkg.sv
package bytedma_pkg;
   typedef enum logic [1:0] {
      SEL_CTRL = 2'd0,
      SEL_ADDR = 2'd1,
      SEL_CNT  = 2'd2,
      SEL_REST = 2'd3
   } regsel_e;

   localparam int CTL_DIR_BIT  = 0;
   localparam int CTL_EN_BIT   = 1;
   localparam int STS_DONE_BIT = 6;
   localparam int STS_ERR_BIT  = 7;
endpackage

// File: rtl/bytedma_lanes.sv
module bytedma_lanes #(
   parameter int LANES = 4,
   localparam int DW    = 8 * LANES,
   localparam int OFF_W = $clog2(LANES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             ld_word,
   input  logic [DW-1:0]    word_in,
   input  logic             wr_byte,
   input  logic [OFF_W-1:0] lane_idx,
   input  logic [7:0]       byte_in,
   output logic [DW-1:0]    word_q,
   output logic [DW-1:0]    word_mrg,
   output logic [7:0]       byte_out
);
   for (genvar g = 0; g < LANES; g++) begin : g_lane
      localparam int LO = (LANES - 1 - g) * 8;
      logic [7:0] q;
      logic       hit;
      assign hit = wr_byte && (lane_idx == OFF_W'(g));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       q <= '0;
         else if (clr)     q <= '0;
         else if (ld_word) q <= word_in[LO +: 8];
         else if (hit)     q <= byte_in;
      end
      assign word_q[LO +: 8]   = q;
      assign word_mrg[LO +: 8] = hit ? byte_in : q;
   end

   always_comb begin
      byte_out = '0;
      for (int i = 0; i < LANES; i++) begin
         if (lane_idx == OFF_W'(i)) byte_out = word_q[(LANES - 1 - i) * 8 +: 8];
      end
   end
endmodule

// File: rtl/bytedma_memreq.sv
module bytedma_memreq #(
   parameter int AW = 32,
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          issue,
   input  logic          issue_we,
   input  logic [AW-1:0] issue_addr,
   input  logic [DW-1:0] issue_wdata,
   input  logic          abort,
   output logic          mem_req,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_wdata,
   input  logic          mem_ack,
   input  logic          mem_err,
   output logic          rsp_ok,
   output logic          rsp_err
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem_req   <= 1'b0;
         mem_we    <= 1'b0;
         mem_addr  <= '0;
         mem_wdata <= '0;
      end else if (abort) begin
         mem_req <= 1'b0;
      end else if (mem_req && (mem_ack || mem_err)) begin
         mem_req <= 1'b0;
      end else if (issue) begin
         mem_req   <= 1'b1;
         mem_we    <= issue_we;
         mem_addr  <= issue_addr;
         mem_wdata <= issue_wdata;
      end
   end

   assign rsp_ok  = mem_req && mem_ack && !abort;
   assign rsp_err = mem_req && mem_err && !mem_ack && !abort;
endmodule

// File: rtl/bytedma_rest.sv
module bytedma_rest
   import bytedma_pkg::*;
#(
   parameter int AW    = 32,
   parameter int CW    = 24,
   parameter int LANES = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          reg_we,
   input  logic [1:0]    reg_sel,
   input  logic [31:0]   reg_wdata,
   output logic [31:0]   reg_rdata,
   input  logic          dev_req,
   output logic          dev_ack,
   input  logic [7:0]    dev_rdata,
   output logic [7:0]    dev_wdata,
   output logic          mem_req,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [8*LANES-1:0] mem_wdata,
   input  logic [8*LANES-1:0] mem_rdata,
   input  logic          mem_ack,
   input  logic          mem_err
);
   localparam int DW    = 8 * LANES;
   localparam int OFF_W = $clog2(LANES);

   if (LANES != 2 && LANES != 4) begin : g_bad_lanes
      $error("LANES must be 2 or 4");
   end
   if (AW > 32 || AW < OFF_W + 2) begin : g_bad_aw
      $error("AW out of range");
   end
   if (CW > 32 || CW < 2) begin : g_bad_cw
      $error("CW out of range");
   end

   logic          ctrl_en, ctrl_dir, run, st_err, st_done, buf_valid;
   logic [AW-1:0] addr_q;
   logic [CW-1:0] cnt_q;
   logic [OFF_W-1:0] off;
   logic          last_off, ctl_wr, start, stop, can_go, hs;
   logic          issue_wr, issue_rd, rsp_ok, rsp_err, finish;
   logic [AW-1:0] word_addr;
   logic [DW-1:0] word_q, word_mrg;

   assign off       = addr_q[OFF_W-1:0];
   assign last_off  = (off == OFF_W'(LANES - 1));
   assign word_addr = {addr_q[AW-1:OFF_W], {OFF_W{1'b0}}};
   assign ctl_wr    = reg_we && (regsel_e'(reg_sel) == SEL_CTRL);
   assign start     = ctl_wr && reg_wdata[CTL_EN_BIT] && !ctrl_en;
   assign stop      = ctl_wr && !reg_wdata[CTL_EN_BIT];
   assign can_go    = run && !mem_req && !stop && (cnt_q != '0);
   assign dev_ack   = can_go && dev_req && (!ctrl_dir || buf_valid);
   assign hs        = dev_ack;
   assign issue_wr  = hs && !ctrl_dir && last_off;
   assign issue_rd  = can_go && ctrl_dir && !buf_valid;
   assign finish    = run && !mem_req && !stop && (cnt_q == '0);

   bytedma_lanes #(.LANES(LANES)) i_lanes (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (start || issue_wr),
      .ld_word  (rsp_ok && !mem_we),
      .word_in  (mem_rdata),
      .wr_byte  (hs && !ctrl_dir),
      .lane_idx (off),
      .byte_in  (dev_rdata),
      .word_q   (word_q),
      .word_mrg (word_mrg),
      .byte_out (dev_wdata)
   );

   bytedma_memreq #(.AW(AW), .DW(DW)) i_memreq (
      .clk         (clk),
      .rst_n       (rst_n),
      .issue       (issue_wr || issue_rd),
      .issue_we    (issue_wr),
      .issue_addr  (word_addr),
      .issue_wdata (word_mrg),
      .abort       (stop),
      .mem_req     (mem_req),
      .mem_we      (mem_we),
      .mem_addr    (mem_addr),
      .mem_wdata   (mem_wdata),
      .mem_ack     (mem_ack),
      .mem_err     (mem_err),
      .rsp_ok      (rsp_ok),
      .rsp_err     (rsp_err)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_en   <= 1'b0;
         ctrl_dir  <= 1'b0;
         run       <= 1'b0;
         st_err    <= 1'b0;
         st_done   <= 1'b0;
         buf_valid <= 1'b0;
         addr_q    <= '0;
         cnt_q     <= '0;
      end else if (stop) begin
         ctrl_en   <= 1'b0;
         ctrl_dir  <= reg_wdata[CTL_DIR_BIT];
         run       <= 1'b0;
         st_err    <= 1'b0;
         st_done   <= 1'b0;
         buf_valid <= 1'b0;
      end else if (start) begin
         ctrl_en   <= 1'b1;
         ctrl_dir  <= reg_wdata[CTL_DIR_BIT];
         run       <= 1'b1;
         st_err    <= 1'b0;
         st_done   <= 1'b0;
         buf_valid <= 1'b0;
      end else begin
         if (reg_we && !ctrl_en && regsel_e'(reg_sel) == SEL_ADDR) addr_q <= reg_wdata[AW-1:0];
         if (reg_we && !ctrl_en && regsel_e'(reg_sel) == SEL_CNT)  cnt_q  <= reg_wdata[CW-1:0];
         if (hs) begin
            addr_q <= addr_q + AW'(1);
            cnt_q  <= cnt_q - CW'(1);
            if (ctrl_dir && last_off) buf_valid <= 1'b0;
         end
         if (rsp_ok && !mem_we) buf_valid <= 1'b1;
         if (rsp_err) begin
            run    <= 1'b0;
            st_err <= 1'b1;
            addr_q <= mem_addr;
         end
         if (finish) begin
            run     <= 1'b0;
            st_done <= 1'b1;
         end
      end
   end

   always_comb begin
      reg_rdata = '0;
      unique case (regsel_e'(reg_sel))
         SEL_CTRL: begin
            reg_rdata[STS_ERR_BIT]  = st_err;
            reg_rdata[STS_DONE_BIT] = st_done;
            reg_rdata[CTL_EN_BIT]   = ctrl_en;
            reg_rdata[CTL_DIR_BIT]  = ctrl_dir;
         end
         SEL_ADDR: reg_rdata[AW-1:0] = addr_q;
         SEL_CNT:  reg_rdata[CW-1:0] = cnt_q;
         SEL_REST: reg_rdata[DW-1:0] = word_q;
         default:  reg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/bytedma_rest_chk.sv
module bytedma_rest_chk #(
   parameter int AW = 32,
   parameter int CW = 24
) (
   input logic          clk,
   input logic          rst_n,
   input logic          reg_we,
   input logic [1:0]    reg_sel,
   input logic [31:0]   reg_wdata,
   input logic          dev_req,
   input logic          dev_ack,
   input logic          mem_req,
   input logic [AW-1:0] mem_addr,
   input logic          mem_ack,
   input logic          mem_err,
   input logic          st_err,
   input logic          st_done,
   input logic          ctrl_en,
   input logic [AW-1:0] addr_q,
   input logic [CW-1:0] cnt_q
);
   logic ctl_stop;
   assign ctl_stop = reg_we && reg_sel == 2'd0 && !reg_wdata[1];

   a_r3_ack_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
      dev_ack |-> dev_req);

   a_r4_no_ack_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
      dev_ack |-> !mem_req);

   a_r3_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> mem_addr[1:0] == 2'b00);

   a_r3_count_step: assert property (@(posedge clk) disable iff (!rst_n)
      (dev_ack && dev_req) |=> cnt_q == CW'($past(cnt_q) - 1'b1));

   a_r8_error_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_err && !mem_ack && !ctl_stop) |=> (st_err && !st_done && addr_q == $past(mem_addr)));

   a_r9_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_stop |=> (!st_err && !st_done && !mem_req && !ctrl_en));

   a_r2_addr_locked: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_sel == 2'd1 && ctrl_en && !dev_ack && !(mem_req && mem_err) && !ctl_stop)
      |=> $stable(addr_q));

   a_r3_req_held: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack && !mem_err && !ctl_stop) |=> (mem_req && $stable(mem_addr)));

   a_r7_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(st_err && st_done));
endmodule

bind bytedma_rest bytedma_rest_chk #(.AW(AW), .CW(CW)) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_we    (reg_we),
   .reg_sel   (reg_sel),
   .reg_wdata (reg_wdata),
   .dev_req   (dev_req),
   .dev_ack   (dev_ack),
   .mem_req   (mem_req),
   .mem_addr  (mem_addr),
   .mem_ack   (mem_ack),
   .mem_err   (mem_err),
   .st_err    (st_err),
   .st_done   (st_done),
   .ctrl_en   (ctrl_en),
   .addr_q    (addr_q),
   .cnt_q     (cnt_q)
);

// File: tb/test_bytedma_rest.sv
`timescale 1ns/1ps
module test_bytedma_rest;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [1:0]  reg_sel = 2'd0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        dev_req = 1'b0;
   logic        dev_ack;
   logic [7:0]  dev_rdata = '0;
   logic [7:0]  dev_wdata;
   logic        mem_req, mem_we;
   logic [31:0] mem_addr, mem_wdata;
   logic [31:0] mem_rdata = '0;
   logic        mem_ack = 1'b0;
   logic        mem_err = 1'b0;

   int total = 0;
   int bad = 0;
   int mem_lat = 0;
   int wait_cnt = 0;
   int overlap_cnt = 0;
   int req_seen = 0;
   logic        err_en = 1'b0;
   logic [31:0] err_addr = '0;
   logic [31:0] mem [0:63];

   always #4 clk = ~clk;

   bytedma_rest i_bytedma_rest (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dev_req(dev_req),
      .dev_ack(dev_ack), .dev_rdata(dev_rdata), .dev_wdata(dev_wdata),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
      .mem_err(mem_err)
   );

   always @(negedge clk) begin
      if (dev_ack && mem_req) overlap_cnt++;
      if (mem_req) req_seen++;
      if (mem_ack || mem_err) begin
         mem_ack = 1'b0;
         mem_err = 1'b0;
         wait_cnt = 0;
      end else if (mem_req) begin
         if (wait_cnt >= mem_lat) begin
            if (err_en && mem_addr == err_addr) mem_err = 1'b1;
            else begin
               mem_ack = 1'b1;
               if (mem_we) mem[mem_addr[7:2]] = mem_wdata;
               else mem_rdata = mem[mem_addr[7:2]];
            end
         end else wait_cnt++;
      end else wait_cnt = 0;
   end

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic reg_write(logic [1:0] sel, logic [31:0] d);
      reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
      @(posedge clk);
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic reg_read(logic [1:0] sel, output logic [31:0] d);
      reg_sel = sel;
      #1;
      d = reg_rdata;
   endtask

   task automatic wait_ack(string tag);
      int n = 0;
      #1;
      while (!dev_ack && n < 1000) begin
         @(negedge clk);
         #1;
         n++;
      end
      if (n >= 1000) check(tag, 32'hdead, 32'h0);
   endtask

   task automatic push_byte(logic [7:0] b);
      dev_rdata = b; dev_req = 1'b1;
      wait_ack("push handshake");
      @(posedge clk);
      @(negedge clk);
      dev_req = 1'b0;
   endtask

   task automatic pull_byte(output logic [7:0] b);
      dev_req = 1'b1;
      wait_ack("pull handshake");
      b = dev_wdata;
      @(posedge clk);
      @(negedge clk);
      dev_req = 1'b0;
   endtask

   task automatic wait_status(logic [31:0] mask);
      logic [31:0] s;
      int n = 0;
      reg_read(2'd0, s);
      while ((s & mask) == 0 && n < 1000) begin
         @(negedge clk);
         reg_read(2'd0, s);
         n++;
      end
   endtask

   task automatic setup(logic [31:0] a, logic [31:0] c, logic dir);
      reg_write(2'd0, 32'h0);
      reg_write(2'd1, a);
      reg_write(2'd2, c);
      reg_write(2'd0, {30'd0, 1'b1, dir});
   endtask

   task automatic t_reset;
      logic [31:0] v;
      reg_read(2'd0, v);
      check("R1 status after reset", v, 32'h0);
      dev_req = 1'b1;
      #1;
      check("R1 no ack after reset", {31'd0, dev_ack}, 32'h0);
      check("R1 no mem_req after reset", {31'd0, mem_req}, 32'h0);
      dev_req = 1'b0;
   endtask

   task automatic t_in_odd;
      logic [31:0] v;
      mem_lat = 2;
      overlap_cnt = 0;
      setup(32'h10, 32'd7, 1'b0);
      reg_read(2'd0, v);
      check("R2 status while running", v, 32'h2);
      for (int i = 0; i < 7; i++) push_byte(8'h11 + 8'(i));
      wait_status(32'h40);
      check("R3 word in memory", mem[4], 32'h11121314);
      reg_read(2'd3, v);
      check("R5 residual lanes", v, 32'h15161700);
      reg_read(2'd1, v);
      check("R5 address counts residual", v, 32'h17);
      reg_read(2'd2, v);
      check("R3 count exhausted", v, 32'h0);
      reg_read(2'd0, v);
      check("R7 done status", v, 32'h42);
      check("R4 no ack during memory access", overlap_cnt, 0);
   endtask

   task automatic t_last_word_done;
      logic [31:0] v;
      mem_lat = 6;
      setup(32'h40, 32'd8, 1'b0);
      for (int i = 0; i < 8; i++) push_byte(8'hA0 + 8'(i));
      check("R7 flush pending after last byte", {31'd0, mem_req}, 32'h1);
      reg_read(2'd0, v);
      check("R7 done waits for write", v & 32'h40, 32'h0);
      wait_status(32'h40);
      check("R7 first word", mem[16], 32'hA0A1A2A3);
      check("R7 second word", mem[17], 32'hA4A5A6A7);
      reg_read(2'd1, v);
      check("R5 aligned end address", v, 32'h48);
   endtask

   task automatic t_ignore_writes;
      logic [31:0] v;
      mem_lat = 0;
      setup(32'h50, 32'd4, 1'b0);
      reg_write(2'd1, 32'h99);
      reg_write(2'd2, 32'h77);
      reg_read(2'd1, v);
      check("R2 address write ignored", v, 32'h50);
      reg_read(2'd2, v);
      check("R2 count write ignored", v, 32'h4);
      for (int i = 0; i < 4; i++) push_byte(8'h31 + 8'(i));
      wait_status(32'h40);
      check("R3 word after ignored writes", mem[20], 32'h31323334);
   endtask

   task automatic t_out;
      logic [31:0] v;
      logic [7:0]  b;
      logic [7:0]  exp [5] = '{8'hA2, 8'hA3, 8'hA4, 8'hB1, 8'hB2};
      mem_lat = 1;
      mem[8] = 32'hA1A2A3A4;
      mem[9] = 32'hB1B2B3B4;
      setup(32'h21, 32'd5, 1'b1);
      reg_read(2'd0, v);
      check("R2 status dir out", v, 32'h3);
      for (int i = 0; i < 5; i++) begin
         pull_byte(b);
         check("R6 outbound byte", {24'd0, b}, {24'd0, exp[i]});
      end
      wait_status(32'h40);
      reg_read(2'd0, v);
      check("R7 outbound done", v, 32'h43);
      reg_read(2'd1, v);
      check("R6 outbound end address", v, 32'h26);
   endtask

   task automatic t_bus_error;
      logic [31:0] v;
      mem_lat = 1;
      err_en = 1'b1;
      err_addr = 32'h30;
      setup(32'h30, 32'd8, 1'b0);
      for (int i = 0; i < 4; i++) push_byte(8'h51 + 8'(i));
      wait_status(32'h80);
      reg_read(2'd0, v);
      check("R8 error status", v, 32'h82);
      reg_read(2'd1, v);
      check("R8 address at faulting word", v, 32'h30);
      dev_req = 1'b1;
      repeat (3) @(negedge clk);
      #1;
      check("R8 no handshake after error", {31'd0, dev_ack}, 32'h0);
      dev_req = 1'b0;
      err_en = 1'b0;
   endtask

   task automatic t_stop;
      logic [31:0] v;
      mem_lat = 0;
      setup(32'h60, 32'd6, 1'b0);
      push_byte(8'hC1);
      push_byte(8'hC2);
      reg_write(2'd0, 32'h0);
      reg_read(2'd0, v);
      check("R9 status cleared by stop", v, 32'h0);
      dev_req = 1'b1;
      #1;
      check("R9 no handshake after stop", {31'd0, dev_ack}, 32'h0);
      dev_req = 1'b0;
      reg_read(2'd3, v);
      check("R5 residual after stop", v, 32'hC1C20000);
      reg_read(2'd1, v);
      check("R5 address after stop", v, 32'h62);
   endtask

   task automatic t_zero;
      logic [31:0] v;
      setup(32'h70, 32'd0, 1'b0);
      req_seen = 0;
      dev_req = 1'b1;
      #1;
      check("R10 no handshake at zero count", {31'd0, dev_ack}, 32'h0);
      repeat (3) @(negedge clk);
      dev_req = 1'b0;
      reg_read(2'd0, v);
      check("R10 immediate done", v, 32'h42);
      check("R10 no memory access", req_seen, 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      for (int i = 0; i < 64; i++) mem[i] = '0;
      repeat (3) @(negedge clk);
      t_reset;
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_in_odd;
      t_last_word_done;
      t_ignore_writes;
      t_out;
      t_bus_error;
      t_stop;
      t_zero;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule